// File: doc/BRIEF.md
# Delay-Setting Program Interface

This block keeps the 8-bit code that selects the tap of a programmable delay element. A host can load the code in three ways, chosen by a mode pin. With mode high the parallel bus is used: while the address enable is high the code tracks the bus, and when the enable drops the last bus value stays in place. With mode low the code is loaded over a three-wire serial port. Bits enter a separate input register, most significant bit first, on each rising edge of the serial clock while the enable is high. The code in the input register becomes the active setting when the enable drops.

Bits pushed into the input register push its old contents out on the serial output, again most significant bit first. Several units can therefore be chained, with eight bits per unit. The same path gives readback. Reading is destructive, so a host that wants to keep the code shifts the value it read back in before it drops the enable. The serial output shares a pad with parallel bit 0. The block drives that pad only in serial mode while the enable is high.

All pins are sampled by a system clock that runs at least four times faster than the serial clock. Every pin passes through the same synchroniser chain. The enable and the serial clock are then turned into single-cycle edge pulses. A one-cycle strobe marks every change of the active setting.

Top module: `dly_prog_if`

## Requirements
- R1: After reset the active setting and the serial input register are all zeros, the update strobe is low and the serial output is not driven.
- R2: With mode high (parallel) and enable high, the active setting takes the parallel bus value and follows every change of it.
- R3: With mode high, after the enable falls the active setting keeps the last bus value seen while the enable was high, and later bus changes have no effect.
- R4: With mode low (serial) and enable high, each rising serial clock edge shifts the serial data bit into bit 0 of the input register and moves every other bit up one place. Serial clock edges while the enable is low change nothing.
- R5: With mode low, the active setting stays unchanged while bits are shifted, and takes the input register value when the enable falls.
- R6: While the serial output is driven it shows bit 7 of the input register. That bit is valid once the enable has risen, before any clock edge, and the next lower old bit follows after each rising clock edge. After 8 clocks the output presents the first bit shifted in, so a second unit can be chained.
- R7: Shifting in 8 bits replaces the stored register value, so a read is destructive. Writing the read value back before the enable falls leaves the setting unchanged.
- R8: The serial output enable is high exactly when the synchronised mode is low and the synchronised enable is high. Otherwise the shared pad is left to act as parallel bit 0.
- R9: The update strobe is high for one cycle exactly when the active setting changes. Loading the same value again gives no strobe.
- R10: Every pin passes through SYNC_STAGES flops, and the enable and serial clock edges become single-cycle pulses. A parallel change made before clock edge k shows on the setting after edge k+SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 selects parallel loading, 0 selects serial |
| aen_i | input | 1 | Address enable |
| par_i | input | SET_W | Parallel code bus; bit 0 is the shared pad |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (bit 7 of input register) |
| sdo_oe_o | output | 1 | Drive enable for the shared pad |
| setting_o | output | SET_W | Active delay setting |
| upd_o | output | 1 | One-cycle strobe on a setting change |

## Verification
The assertions assume that pins change slowly compared with the system clock. Each serial clock level must last at least two system cycles, so that every edge gives exactly one pulse. Data and mode must be steady around the serial clock and enable edges, so that the synchronised copies seen together belong to the same moment. The bench changes inputs only on falling system clock edges. It holds each serial clock level for three cycles and sets serial data two cycles before the rising edge. It changes mode only while the enable is low. A behavioural model delays the pins through a queue and is compared with the outputs on every cycle. Directed checks cover readback, chaining, write-back and ignored clocks.

// File: rtl/dp_prog_pkg.sv
package dp_prog_pkg;
   typedef enum logic {
      MODE_SERIAL   = 1'b0,
      MODE_PARALLEL = 1'b1
   } prog_mode_e;

   localparam int unsigned DEF_SET_W   = 8;
   localparam int unsigned DEF_SYNC    = 2;
   localparam int unsigned CTRL_PINS   = 4;
endpackage

// File: rtl/dp_sync.sv
module dp_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dp_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("dp_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dp_edge_pulse.sv
module dp_edge_pulse #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_i;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse_o = sig_i & ~prev_q;
      end else begin : g_fall
         assign pulse_o = ~sig_i & prev_q;
      end
   endgenerate

   // R10: an edge yields exactly one pulse cycle
   assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/dp_shift_reg.sv
module dp_shift_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         sdi_i,
   output logic [W-1:0] sreg_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("dp_shift_reg: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sreg_o <= '0;
      else if (shift_i) sreg_o <= {sreg_o[W-2:0], sdi_i};
   end

   assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> (sreg_o[0] == $past(sdi_i)) && (sreg_o[W-1:1] == $past(sreg_o[W-2:0])));

   assert_shift_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(sreg_o));
endmodule

// File: rtl/dp_setting_reg.sv
module dp_setting_reg
   import dp_prog_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  prog_mode_e   mode_i,
   input  logic         aen_i,
   input  logic         aen_fall_i,
   input  logic [W-1:0] par_i,
   input  logic [W-1:0] sreg_i,
   output logic [W-1:0] setting_o,
   output logic         upd_o
);
   logic [W-1:0] next_set;

   always_comb begin
      next_set = setting_o;
      unique case (mode_i)
         MODE_PARALLEL: if (aen_i)      next_set = par_i;
         MODE_SERIAL:   if (aen_fall_i) next_set = sreg_i;
         default:       next_set = setting_o;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setting_o <= '0;
         upd_o     <= 1'b0;
      end else begin
         setting_o <= next_set;
         upd_o     <= (next_set != setting_o);
      end
   end

   assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_PARALLEL && aen_i) |=> setting_o == $past(par_i));

   assert_par_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_PARALLEL && !aen_i) |=> $stable(setting_o));

   assert_upd_marks_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (setting_o != $past(setting_o)) |-> upd_o);

   assert_upd_only_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |-> (setting_o != $past(setting_o)));
endmodule

// File: rtl/dly_prog_if.sv
module dly_prog_if
   import dp_prog_pkg::*;
#(
   parameter int unsigned SET_W       = DEF_SET_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_i,
   input  logic             aen_i,
   input  logic [SET_W-1:0] par_i,
   input  logic             sclk_i,
   input  logic             sdi_i,
   output logic             sdo_o,
   output logic             sdo_oe_o,
   output logic [SET_W-1:0] setting_o,
   output logic             upd_o
);
   localparam int unsigned PIN_W = SET_W + CTRL_PINS;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dly_prog_if: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PIN_W-1:0] pins_raw, pins_s;
   logic             s_mode, s_aen, s_sclk, s_sdi;
   logic [SET_W-1:0] s_par;
   logic             sclk_rise, aen_fall, shift_en;
   logic [SET_W-1:0] sreg;
   prog_mode_e       mode_e;

   assign pins_raw = {mode_i, aen_i, sclk_i, sdi_i, par_i};

   dp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   assign {s_mode, s_aen, s_sclk, s_sdi, s_par} = pins_s;
   assign mode_e = prog_mode_e'(s_mode);

   dp_edge_pulse #(.RISING(1'b1)) u_sclk_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sig_i   (s_sclk),
      .pulse_o (sclk_rise)
   );

   dp_edge_pulse #(.RISING(1'b0)) u_aen_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sig_i   (s_aen),
      .pulse_o (aen_fall)
   );

   assign shift_en = sclk_rise & s_aen & (mode_e == MODE_SERIAL);

   dp_shift_reg #(.W(SET_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift_en),
      .sdi_i   (s_sdi),
      .sreg_o  (sreg)
   );

   dp_setting_reg #(.W(SET_W)) u_setting (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_e),
      .aen_i      (s_aen),
      .aen_fall_i (aen_fall),
      .par_i      (s_par),
      .sreg_i     (sreg),
      .setting_o  (setting_o),
      .upd_o      (upd_o)
   );

   assign sdo_o    = sreg[SET_W-1];
   assign sdo_oe_o = s_aen & (mode_e == MODE_SERIAL);

   // R5: a serial-mode enable fall commits the shifted code
   assert_serial_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (aen_fall && mode_e == MODE_SERIAL) |=> setting_o == $past(sreg));

   // R5: no change of setting in serial mode without an enable fall
   assert_serial_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == MODE_SERIAL && !aen_fall) |=> $stable(setting_o));

   // R6: each shift exposes the next lower old bit on the output
   assert_sdo_next_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> sdo_o == $past(sreg[SET_W-2]));
endmodule

// File: tb/tb_dly_prog_if.sv
module tb_dly_prog_if;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int SYNC       = 2;

   logic         clk, rst_n, mode, aen, sclk, sdi;
   logic [W-1:0] par;
   logic         sdo, sdo_oe, upd;
   logic [W-1:0] setting;

   dly_prog_if #(.SET_W(W), .SYNC_STAGES(SYNC)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode),
      .aen_i     (aen),
      .par_i     (par),
      .sclk_i    (sclk),
      .sdi_i     (sdi),
      .sdo_o     (sdo),
      .sdo_oe_o  (sdo_oe),
      .setting_o (setting),
      .upd_o     (upd)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   int upd_cnt = 0;
   bit done = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct packed {
      logic         mode;
      logic         aen;
      logic         sclk;
      logic         sdi;
      logic [W-1:0] par;
   } pin_t;

   pin_t         hist[$];
   logic [W-1:0] m_set, m_sreg;
   logic         m_upd;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i <= SYNC; i++) hist.push_back('0);
         m_set  = '0;
         m_sreg = '0;
         m_upd  = 1'b0;
      end else begin
         pin_t         old_p, cur_p;
         logic [W-1:0] nxt;
         old_p = hist[0];
         cur_p = hist[1];
         nxt   = m_set;
         if (cur_p.mode && cur_p.aen) nxt = cur_p.par;
         if (!cur_p.mode && !cur_p.aen && old_p.aen) nxt = m_sreg;
         if (!cur_p.mode && cur_p.aen && cur_p.sclk && !old_p.sclk)
            m_sreg = {m_sreg[W-2:0], cur_p.sdi};
         m_upd = (nxt != m_set);
         m_set = nxt;
         void'(hist.pop_front());
         hist.push_back({mode, aen, sclk, sdi, par});
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && hist.size() == SYNC + 1) begin
         pin_t vis;
         vis = hist[SYNC-1];
         check("R10 setting vs model", setting, m_set);
         check("R9 strobe vs model", upd, m_upd);
         check("R8 output enable vs model", sdo_oe, (!vis.mode && vis.aen));
         if (sdo_oe) check("R6 serial out vs model", sdo, m_sreg[W-1]);
         if (upd) upd_cnt++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, output logic seen);
      sdi = b;
      cyc(2);
      seen = sdo;
      sclk = 1'b1;
      cyc(3);
      sclk = 1'b0;
      cyc(3);
   endtask

   task automatic xfer(input logic [W-1:0] wr, output logic [W-1:0] rd);
      for (int i = W - 1; i >= 0; i--) begin
         logic s;
         send_bit(wr[i], s);
         rd[i] = s;
      end
   endtask

   task automatic open_serial();
      mode = 1'b0;
      aen  = 1'b1;
      cyc(5);
   endtask

   task automatic close_serial();
      aen = 1'b0;
      cyc(6);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R10: actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [W-1:0] rd, rd2;
      int           snap;
      rst_n = 1'b0; mode = 1'b0; aen = 1'b0; sclk = 1'b0; sdi = 1'b0; par = '0;
      cyc(5);
      rst_n = 1'b1;
      cyc(1);
      check("R1 reset setting", setting, 8'h00);
      check("R1 reset strobe", upd, 1'b0);
      check("R1 reset output enable", sdo_oe, 1'b0);

      // transparent parallel, with latency count
      mode = 1'b1; aen = 1'b1; par = 8'h5A;
      cyc(2);
      check("R10 setting before sync delay", setting, 8'h00);
      cyc(1);
      check("R2 transparent load", setting, 8'h5A);
      check("R9 strobe on change", upd, 1'b1);
      par = 8'hC3;
      cyc(4);
      check("R2 transparent follow", setting, 8'hC3);
      check("R8 no drive in parallel mode", sdo_oe, 1'b0);

      // latched parallel
      par = 8'h3C;
      cyc(4);
      aen = 1'b0;
      cyc(1);
      par = 8'hFF;
      cyc(6);
      check("R3 latched value kept", setting, 8'h3C);

      // serial write, reading old (reset) contents
      open_serial();
      check("R8 drive in serial mode", sdo_oe, 1'b1);
      check("R6 bit 7 before clocks", sdo, 1'b0);
      xfer(8'h96, rd);
      check("R7 read of previous contents", rd, 8'h00);
      check("R5 setting held while shifting", setting, 8'h3C);
      close_serial();
      check("R5 commit on enable fall", setting, 8'h96);
      check("R8 released after enable fall", sdo_oe, 1'b0);

      // serial clocks with enable low must be ignored
      sdi = 1'b1;
      for (int k = 0; k < 4; k++) begin
         sclk = 1'b1; cyc(3);
         sclk = 1'b0; cyc(3);
      end
      open_serial();
      check("R6 bit 7 valid after enable rise", sdo, 1'b1);
      xfer(8'h96, rd);
      check("R4 clocks with enable low ignored", rd, 8'h96);
      snap = upd_cnt;
      close_serial();
      check("R7 write-back keeps setting", setting, 8'h96);
      check("R9 no strobe for same value", upd_cnt - snap, 0);

      // chained pair: second byte pushes first one out
      open_serial();
      xfer(8'hA5, rd);
      xfer(8'h1E, rd2);
      check("R6 own contents out first", rd, 8'h96);
      check("R6 cascade pass-through", rd2, 8'hA5);
      snap = upd_cnt;
      close_serial();
      check("R5 commit last byte", setting, 8'h1E);
      check("R9 one strobe per change", upd_cnt - snap, 1);

      // destructive read
      open_serial();
      xfer(8'h00, rd);
      check("R7 read returns stored code", rd, 8'h1E);
      close_serial();
      check("R7 read destroys code", setting, 8'h00);

      // back to parallel
      par = 8'h77;
      mode = 1'b1;
      cyc(2);
      aen = 1'b1;
      cyc(5);
      check("R2 parallel after serial", setting, 8'h77);
      check("R8 pad released in parallel", sdo_oe, 1'b0);
      aen = 1'b0;
      cyc(4);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule